// File: doc/BRIEF.md
# 32-bit ALU with persistent condition flags

This block is the data-processing stage of a 32-bit integer pipeline. Each cycle it takes an operation code, two operands and a flag-update enable, and combinationally produces a 32-bit result and a destination-write enable. It also keeps a four-bit status register {N, Z, C, V}. The status register changes only when an enabled update, a compare/test operation, or the direct flag-write port asks for it. Otherwise it holds its value for any number of cycles.

Flag behaviour depends on the operation class. Arithmetic operations produce C from the carry out of bit 31 and V from signed overflow. Logical operations leave V alone. They take C from the shifter carry-out that comes in beside the operand, or keep C when no shift happened. Compare and test operations always write the flags and never write a destination.

Top module: `alu_nzcv`

Operation codes (`op_i`):

| Code | Operation | Result | Class |
|---|---|---|---|
| 0 | AND | a & b | logical |
| 1 | XOR | a ^ b | logical |
| 2 | SUB | a − b | arithmetic |
| 3 | RSUB | b − a | arithmetic |
| 4 | ADD | a + b | arithmetic |
| 5 | ADDC | a + b + C | arithmetic |
| 6 | SUBC | a + ~b + C | arithmetic |
| 7 | RSUBC | b + ~a + C | arithmetic |
| 8 | TESTAND | a & b, flags only | logical |
| 9 | TESTXOR | a ^ b, flags only | logical |
| A | CMPSUB | a − b, flags only | arithmetic |
| B | CMPADD | a + b, flags only | arithmetic |
| C | OR | a \| b | logical |
| D | MOVE | b | logical |
| E | ANDNOT | a & ~b | logical |
| F | MOVENOT | ~b | logical |

## Requirements
- R1: When flag_wr_i is 0, set_flags_i is 0 and op_i is not 8 to B, flags_o keeps its value across the clock edge, however many such cycles follow.
- R2: Ops 8 to B (compare/test) update flags_o even when set_flags_i is 0. For these ops rd_we_o is 0; for every other op it is 1.
- R3: For logical ops (0, 1, 8, 9, C, D, E, F), V (flags_o[0]) is left unchanged by an update.
- R4: For logical ops, an update sets C (flags_o[1]) to shift_carry_i when shift_valid_i is 1, and keeps C when shift_valid_i is 0.
- R5: On every flag update, N (flags_o[3]) becomes bit 31 of the result and Z (flags_o[2]) becomes 1 exactly when the 32-bit result is zero.
- R6: For arithmetic ops, an update sets C to the carry out of bit 31. Subtraction is computed as x + ~y + 1, so C = 1 means no borrow occurred.
- R7: For arithmetic ops, V is set when the signed two's-complement result does not fit in 32 bits, and result_o holds the low 32 bits of the sum.
- R8: When flag_wr_i is 1, flags_o loads flag_wdata_i ({N,Z,C,V}) at the clock edge. This takes priority over any ALU update in the same cycle.
- R9: During and after reset (rst_n low), flags_o is 0000.
- R10: ADDC, SUBC and RSUBC use the current C flag as carry-in. RSUB and RSUBC swap the roles of a and b.
- R11: The logical ops give the results listed in the table: AND, XOR, OR, ANDNOT (a & ~b), MOVE (b) and MOVENOT (~b).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_i | input | 4 | Operation code |
| opa_i | input | 32 | First operand |
| opb_i | input | 32 | Second operand (shifter output) |
| set_flags_i | input | 1 | Flag-update enable |
| shift_carry_i | input | 1 | Last bit shifted out by the shifter |
| shift_valid_i | input | 1 | A shift took place |
| flag_wr_i | input | 1 | Direct flag write |
| flag_wdata_i | input | 4 | Direct flag value {N,Z,C,V} |
| result_o | output | 32 | Operation result |
| rd_we_o | output | 1 | Destination-write enable |
| flags_o | output | 4 | Current flags {N,Z,C,V} |

## Verification
An ALU flag update and a direct flag write can fall in the same cycle. The bench provokes this with directed cases, such as an overflowing add with the update enabled while the port writes N-only, and with random cycles that assert flag_wr_i alongside random operations and enables. In every such cycle the flags after the edge are judged against the written value, never the computed one. The next operation's carry-in is then checked to confirm it uses the written C.

// File: rtl/alu_nzcv.sv
module alu_nzcv #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [3:0]   op_i,
  input  logic [W-1:0] opa_i,
  input  logic [W-1:0] opb_i,
  input  logic         set_flags_i,
  input  logic         shift_carry_i,
  input  logic         shift_valid_i,
  input  logic         flag_wr_i,
  input  logic [3:0]   flag_wdata_i,
  output logic [W-1:0] result_o,
  output logic         rd_we_o,
  output logic [3:0]   flags_o
);
  localparam logic [3:0] OP_AND = 4'h0, OP_XOR = 4'h1, OP_SUB = 4'h2, OP_RSUB = 4'h3,
                         OP_ADD = 4'h4, OP_ADDC = 4'h5, OP_SUBC = 4'h6, OP_RSUBC = 4'h7,
                         OP_TAND = 4'h8, OP_TXOR = 4'h9, OP_CSUB = 4'hA, OP_CADD = 4'hB,
                         OP_OR = 4'hC, OP_MOVE = 4'hD, OP_ANDN = 4'hE, OP_MOVEN = 4'hF;

  logic [3:0]   flags_q;
  logic         c_cur;
  logic [W-1:0] x, y;
  logic         cin;
  logic [W:0]   sum;
  logic [W-1:0] lres;
  logic         is_arith, is_cmp, upd;
  logic         n_new, z_new, c_new, v_new;

  assign c_cur   = flags_q[1];
  assign is_cmp  = (op_i[3:2] == 2'b10);
  assign is_arith = (op_i[3:2] == 2'b01) || (op_i[3:1] == 3'b001) || (op_i[3:1] == 3'b101);
  assign upd     = set_flags_i || is_cmp;

  always_comb begin
    x = opa_i; y = opb_i; cin = 1'b0;
    unique case (op_i)
      OP_SUB, OP_CSUB: begin y = ~opb_i; cin = 1'b1; end
      OP_RSUB:  begin x = opb_i; y = ~opa_i; cin = 1'b1; end
      OP_ADDC:  cin = c_cur;
      OP_SUBC:  begin y = ~opb_i; cin = c_cur; end
      OP_RSUBC: begin x = opb_i; y = ~opa_i; cin = c_cur; end
      default:  ;
    endcase
  end

  assign sum = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};

  always_comb begin
    unique case (op_i)
      OP_AND, OP_TAND: lres = opa_i & opb_i;
      OP_XOR, OP_TXOR: lres = opa_i ^ opb_i;
      OP_OR:    lres = opa_i | opb_i;
      OP_MOVE:  lres = opb_i;
      OP_ANDN:  lres = opa_i & ~opb_i;
      OP_MOVEN: lres = ~opb_i;
      default:  lres = '0;
    endcase
  end

  assign result_o = is_arith ? sum[W-1:0] : lres;
  assign rd_we_o  = !is_cmp;

  assign n_new = result_o[W-1];
  assign z_new = (result_o == '0);
  assign c_new = is_arith ? sum[W] : (shift_valid_i ? shift_carry_i : c_cur);
  assign v_new = is_arith ? ((x[W-1] == y[W-1]) && (sum[W-1] != x[W-1])) : flags_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          flags_q <= 4'b0000;
    else if (flag_wr_i)  flags_q <= flag_wdata_i;
    else if (upd)        flags_q <= {n_new, z_new, c_new, v_new};
  end

  assign flags_o = flags_q;

  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_wr_i && !set_flags_i && !is_cmp) |=> $stable(flags_o));

  assert_logic_v_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_wr_i && !is_arith) |=> flags_o[0] == $past(flags_o[0]));

  assert_logic_c_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_wr_i && upd && !is_arith && !shift_valid_i) |=> flags_o[1] == $past(flags_o[1]));

  assert_nz_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_wr_i && upd) |=> (flags_o[3] == $past(result_o[W-1])) && (flags_o[2] == ($past(result_o) == '0)));

  assert_direct_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flag_wr_i |=> flags_o == $past(flag_wdata_i));
endmodule

// File: tb/alu_nzcv_tb.sv
module alu_nzcv_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [3:0]  op;
  logic [31:0] a, b;
  logic        sf, sc, sv, fw;
  logic [3:0]  fwd;
  logic [31:0] res;
  logic        we;
  logic [3:0]  flags;
  logic [3:0]  mflags = 4'b0000;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  alu_nzcv u_dut (.clk(clk), .rst_n(rst_n), .op_i(op), .opa_i(a), .opb_i(b),
    .set_flags_i(sf), .shift_carry_i(sc), .shift_valid_i(sv), .flag_wr_i(fw),
    .flag_wdata_i(fwd), .result_o(res), .rd_we_o(we), .flags_o(flags));

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h (op %h a %h b %h)", tag, got, exp, op, a, b);
    end
  endtask

  function automatic logic [36:0] model(logic [3:0] o, logic [31:0] x0, logic [31:0] y0,
                                        logic s, logic shc, logic shv, logic [3:0] f);
    logic [32:0] s33; logic [31:0] r, x, y; logic ci, ar, cmp, n, z, c, v; logic [3:0] nf;
    ar = 0; x = x0; y = y0; ci = 0;
    case (o)
      4'h2, 4'hA: begin ar = 1; y = ~y0; ci = 1; end
      4'h3: begin ar = 1; x = y0; y = ~x0; ci = 1; end
      4'h4, 4'hB: ar = 1;
      4'h5: begin ar = 1; ci = f[1]; end
      4'h6: begin ar = 1; y = ~y0; ci = f[1]; end
      4'h7: begin ar = 1; x = y0; y = ~x0; ci = f[1]; end
      default: ;
    endcase
    s33 = {1'b0, x} + {1'b0, y} + 33'(ci);
    case (o)
      4'h0, 4'h8: r = x0 & y0;
      4'h1, 4'h9: r = x0 ^ y0;
      4'hC: r = x0 | y0;
      4'hD: r = y0;
      4'hE: r = x0 & ~y0;
      4'hF: r = ~y0;
      default: r = s33[31:0];
    endcase
    cmp = (o >= 4'h8 && o <= 4'hB);
    n = r[31]; z = (r == 0);
    c = ar ? s33[32] : (shv ? shc : f[1]);
    v = ar ? ((x[31] == y[31]) && (r[31] != x[31])) : f[0];
    nf = (s || cmp) ? {n, z, c, v} : f;
    return {!cmp, nf, r};
  endfunction

  task automatic step(logic [3:0] o, logic [31:0] x, logic [31:0] y, logic s,
                      logic shc, logic shv, logic w, logic [3:0] wd);
    logic [36:0] m; logic [3:0] nf; string rt, ft; logic ar, cmp;
    @(negedge clk);
    op = o; a = x; b = y; sf = s; sc = shc; sv = shv; fw = w; fwd = wd;
    #5;
    m = model(o, x, y, s, shc, shv, mflags);
    cmp = (o >= 4'h8 && o <= 4'hB);
    ar = (o inside {4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'h7, 4'hA, 4'hB});
    rt = ar ? (o inside {4'h5, 4'h6, 4'h7, 4'h3} ? "R10 result" : "R7 result") : "R11 result";
    chk(rt, res, m[31:0]);
    chk("R2 rd_we", 32'(we), 32'(m[36]));
    nf = w ? wd : m[35:32];
    if (w) ft = "R8 flags";
    else if (cmp) ft = "R2 flags";
    else if (!s) ft = "R1 flags";
    else if (ar) ft = "R6/R7 flags";
    else ft = "R3/R4/R5 flags";
    @(posedge clk); #5;
    chk(ft, 32'(flags), 32'(nf));
    mflags = nf;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED1234));
    op = 0; a = 0; b = 0; sf = 0; sc = 0; sv = 0; fw = 0; fwd = 0;
    repeat (3) @(posedge clk);
    #5 chk("R9 reset flags", 32'(flags), 32'h0);
    @(negedge clk) rst_n = 1;
    // R7 signed overflow on add: N=1 Z=0 C=0 V=1
    step(4'h4, 32'h7FFFFFFF, 32'h1, 1, 0, 0, 0, 0);
    // R6 subtract equal: Z=1, C=1 (no borrow), V=0
    step(4'h2, 32'd5, 32'd5, 1, 0, 0, 0, 0);
    // R6 borrow: 0-1 gives C=0, N=1
    step(4'h2, 32'd0, 32'd1, 1, 0, 0, 0, 0);
    // R1 hold across several non-updating ops
    for (int i = 0; i < 5; i++) step(4'h4, 32'hFFFFFFFF, 32'hFFFFFFFF, 0, 1, 1, 0, 0);
    // R2 compare with enable low still updates, no write
    step(4'hA, 32'd9, 32'd3, 0, 0, 0, 0, 0);
    step(4'h8, 32'hF0, 32'h0F, 0, 1, 1, 0, 0);
    // R4 logical keeps C without shift, takes shifter carry with shift; R3 V held
    step(4'h4, 32'h80000000, 32'h80000000, 1, 0, 0, 0, 0);
    step(4'hD, 32'd0, 32'h12345678, 1, 0, 0, 0, 0);
    step(4'h0, 32'hFFFF0000, 32'h0000FFFF, 1, 0, 1, 0, 0);
    // R10 carry-in use
    step(4'h5, 32'd1, 32'd2, 1, 0, 0, 1, 4'b0010);
    step(4'h5, 32'd1, 32'd2, 1, 0, 0, 0, 0);
    step(4'h7, 32'd3, 32'd10, 1, 0, 0, 0, 0);
    // R8 direct write wins over ALU update, then used as carry
    step(4'h4, 32'h7FFFFFFF, 32'h1, 1, 0, 0, 1, 4'b1000);
    step(4'h6, 32'd10, 32'd3, 1, 0, 0, 0, 0);
    // R11 each logical op
    step(4'hE, 32'hFF00FF00, 32'h0F0F0F0F, 1, 1, 1, 0, 0);
    step(4'hF, 32'd0, 32'h0, 1, 0, 0, 0, 0);
    step(4'hC, 32'h0, 32'h0, 1, 0, 1, 0, 0);
    step(4'h1, 32'hA5A5A5A5, 32'hA5A5A5A5, 1, 0, 0, 0, 0);
    step(4'h9, 32'h1, 32'h3, 0, 1, 0, 0, 0);
    step(4'hB, 32'hFFFFFFFF, 32'h1, 0, 0, 0, 0, 0);
    step(4'h3, 32'd7, 32'd2, 1, 0, 0, 0, 0);
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] x, y;
      x = $urandom; y = $urandom;
      if ($urandom % 8 == 0) x = {$urandom % 2 == 0 ? 1'b1 : 1'b0, 31'h7FFFFFFF};
      if ($urandom % 8 == 0) y = 32'(($urandom % 3));
      step(4'($urandom), x, y, 1'($urandom), 1'($urandom), 1'($urandom),
           ($urandom % 10 == 0), 4'($urandom));
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule